// File: doc/BRIEF.md
# Receive Word Aligner with Requested Realignment

This block sits after a deserializer and delivers receive words that start on the correct bit. Each clock it accepts a raw parallel word of either 8 or 10 bits. It keeps the last three words as one continuous bit stream, with the earliest bit first. It compares a configured alignment pattern against that stream at every starting offset from 0 to width-1. The offset that is currently in use is the boundary. The output word is the slice of the stream that starts at the boundary.

The boundary can only move when the surrounding logic asks for it on the align-request input. In 8-bit mode a rising edge on that input arms a single search. The armed search takes the first match it sees and then disarms. In 10-bit mode the aligner may move each cycle for as long as the input is held high.

The block has two one-cycle status outputs. One marks a move to a different boundary. The other marks the pattern sitting exactly at the current boundary. The mode and the pattern are static settings, captured while reset is held.

Top module: `rx_word_aligner`

## Requirements
- R1: With `cfg_wide`=0 (8-bit words, taken from `rx_word[7:0]`), the pattern length is 8 when `cfg_long`=0 and 16 when `cfg_long`=1. The pattern is `cfg_pattern[L-1:0]`, and bit 0 is the earliest received bit.
- R2: With `cfg_wide`=1 (10-bit words), the pattern length is 7 when `cfg_long`=0 and 10 when `cfg_long`=1. The pattern is taken from the low bits of `cfg_pattern` in the same way.
- R3: In 8-bit mode, a rising edge on `align_req` arms a search. This includes a rise in the same cycle as a match. The search stays armed until a match is found and is then consumed. Holding `align_req` high never arms a second search.
- R4: In 10-bit mode, the boundary may move in any cycle in which `align_req` is high and a match exists. While `align_req` is low the boundary does not change.
- R5: The bit stream is formed from the three most recently accepted words, oldest word first and each word with bit 0 first. A match at offset k means stream bits k..k+L-1 equal the pattern, where k ranges from 0 to width-1. When several offsets match, the lowest offset becomes the new boundary, and it is shown on `boundary`.
- R6: `sync_pulse` is high for exactly one cycle, the cycle after the boundary takes a value different from its previous value. It is low at all other times, including when a match re-selects the current boundary.
- R7: `pattern_seen` is high for one cycle each time the pattern matches at the offset equal to the current boundary.
- R8: `aligned_word` is the registered stream slice of width bits starting at the current boundary. In 8-bit mode bits [9:8] are zero.
- R9: While `rst` is high, the boundary clears to 0, all outputs go low, and the three configuration inputs are captured. After reset, changes on the configuration inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset; also captures configuration |
| rx_word | input | 10 | Raw deserialized word (low 8 bits in 8-bit mode) |
| align_req | input | 1 | Realignment request (edge in 8-bit mode, level in 10-bit mode) |
| cfg_wide | input | 1 | 0: 8-bit words, 1: 10-bit words |
| cfg_long | input | 1 | Selects the longer of the two pattern lengths |
| cfg_pattern | input | 16 | Alignment pattern, earliest bit in bit 0 |
| aligned_word | output | 10 | Word sliced at the current boundary |
| boundary | output | 4 | Current boundary offset |
| sync_pulse | output | 1 | One-cycle pulse on a move to a new boundary |
| pattern_seen | output | 1 | One-cycle pulse when the pattern sits at the current boundary |

## Verification
A corrupted boundary shows on the `boundary` port at the next clock. One clock after that, every bit of `aligned_word` is shifted, and `pattern_seen` stops firing when patterns arrive. A wrong arm state in 8-bit mode shows as an extra or missing move on the first pattern after a request, together with a matching extra or missing `sync_pulse`. Pattern insertions at random offsets, mixed with request traffic, expose such errors within a few words, because every cycle is compared against a bit-level model of the stream.

// File: rtl/rxwa_pkg.sv
package rxwa_pkg;

    localparam int unsigned WORD_WIDE   = 10;
    localparam int unsigned WORD_NARROW = 8;
    localparam int unsigned PAT_MAX     = 16;
    localparam int unsigned HIST_WORDS  = 3;
    localparam int unsigned STREAM_W    = HIST_WORDS * WORD_WIDE;
    localparam int unsigned OFF_W       = $clog2(WORD_WIDE);
    localparam int unsigned CNT_W       = $clog2(WORD_WIDE + 1);
    localparam int unsigned LEN_W       = $clog2(PAT_MAX + 1);

    typedef struct packed {
        logic                 wide;
        logic                 long_pat;
        logic [PAT_MAX-1:0]   pattern;
    } cfg_t;

    function automatic logic [LEN_W-1:0] pat_len(input cfg_t c);
        if (c.wide) return c.long_pat ? LEN_W'(10) : LEN_W'(7);
        return c.long_pat ? LEN_W'(16) : LEN_W'(8);
    endfunction

    function automatic logic [CNT_W-1:0] word_len(input cfg_t c);
        return c.wide ? CNT_W'(WORD_WIDE) : CNT_W'(WORD_NARROW);
    endfunction

endpackage

// File: rtl/rxwa_history.sv
module rxwa_history #(
    parameter int unsigned DW = rxwa_pkg::WORD_WIDE,
    parameter int unsigned NN = rxwa_pkg::WORD_NARROW,
    parameter int unsigned NW = rxwa_pkg::HIST_WORDS,
    localparam int unsigned SW = NW * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          wide,
    output logic [SW-1:0] stream
);

    logic [NW-1:0][DW-1:0] hist_d, hist_q;
    logic [SW-1:0]         wide_s;
    logic [NW*NN-1:0]      narrow_s;

    always_comb begin
        hist_d[0] = din;
        for (int i = 1; i < NW; i++) begin
            hist_d[i] = hist_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= hist_d;
    end

    for (genvar j = 0; j < NW; j++) begin : g_pack
        assign wide_s[j*DW +: DW]   = hist_q[NW-1-j];
        assign narrow_s[j*NN +: NN] = hist_q[NW-1-j][NN-1:0];
    end

    assign stream = wide ? wide_s : {{(SW-NW*NN){1'b0}}, narrow_s};

endmodule

// File: rtl/rxwa_matcher.sv
module rxwa_matcher #(
    parameter int unsigned DW = rxwa_pkg::WORD_WIDE,
    parameter int unsigned PW = rxwa_pkg::PAT_MAX,
    parameter int unsigned SW = rxwa_pkg::STREAM_W,
    localparam int unsigned OW = $clog2(DW),
    localparam int unsigned CW = $clog2(DW + 1)
) (
    input  logic [SW-1:0] stream,
    input  logic [PW-1:0] pattern,
    input  logic [PW-1:0] mask,
    input  logic [CW-1:0] wlen,
    output logic [DW-1:0] hit,
    output logic          any,
    output logic [OW-1:0] low
);

    for (genvar k = 0; k < DW; k++) begin : g_off
        logic [PW-1:0] window;
        assign window = stream[k +: PW];
        assign hit[k] = (k < int'(wlen)) && (((window ^ pattern) & mask) == '0);
    end

    always_comb begin
        low = '0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (hit[i]) low = OW'(i);
        end
    end

    assign any = |hit;

endmodule

// File: rtl/rxwa_shifter.sv
module rxwa_shifter #(
    parameter int unsigned DW = rxwa_pkg::WORD_WIDE,
    parameter int unsigned NN = rxwa_pkg::WORD_NARROW,
    parameter int unsigned SW = rxwa_pkg::STREAM_W,
    localparam int unsigned OW = $clog2(DW)
) (
    input  logic [SW-1:0] stream,
    input  logic [OW-1:0] off,
    input  logic          wide,
    output logic [DW-1:0] word
);

    always_comb begin
        word = stream[off +: DW];
        if (!wide) word[DW-1:NN] = '0;
    end

endmodule

// File: rtl/rxwa_ctrl.sv
module rxwa_ctrl
    import rxwa_pkg::*;
#(
    parameter int unsigned DW = WORD_WIDE,
    localparam int unsigned OW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  cfg_t          cfg_in,
    input  logic          align_req,
    input  logic [DW-1:0] hit,
    input  logic          any,
    input  logic [OW-1:0] low,
    input  logic [DW-1:0] word_in,
    output cfg_t          cfg_q,
    output logic [OW-1:0] k_q,
    output logic          sync_q,
    output logic          detect_q,
    output logic [DW-1:0] dout_q
);

    typedef struct packed {
        cfg_t          cfg;
        logic [OW-1:0] k;
        logic          armed;
        logic          req_prev;
        logic          sync;
        logic          detect;
        logic [DW-1:0] dout;
    } st_t;

    st_t st_d, st_q;
    logic rise, armed_eff, move;

    always_comb begin
        rise      = align_req & ~st_q.req_prev;
        armed_eff = st_q.cfg.wide ? align_req : (st_q.armed | rise);
        move      = armed_eff & any;

        st_d          = st_q;
        st_d.req_prev = align_req;
        st_d.armed    = st_q.cfg.wide ? 1'b0 : (armed_eff & ~any);
        st_d.k        = move ? low : st_q.k;
        st_d.sync     = move && (low != st_q.k);
        st_d.detect   = hit[st_q.k];
        st_d.dout     = word_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            st_q.cfg <= cfg_in;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q    = st_q.cfg;
    assign k_q      = st_q.k;
    assign sync_q   = st_q.sync;
    assign detect_q = st_q.detect;
    assign dout_q   = st_q.dout;

    // R6: a pulse only ever accompanies a changed boundary
    p_sync_moves_r6: assert property (@(posedge clk) disable iff (rst)
        st_q.sync |-> (st_q.k != $past(st_q.k)));

    // R6: without a pulse the boundary holds
    p_quiet_holds_r6: assert property (@(posedge clk) disable iff (rst)
        !st_q.sync |-> $stable(st_q.k));

    // R4: level mode with request low never moves
    p_level_low_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.cfg.wide && !align_req) |=> $stable(st_q.k));

    // R3: edge mode with no arm and no rising edge never moves
    p_unarmed_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (!st_q.cfg.wide && !st_q.armed && !(align_req && !st_q.req_prev))
        |=> $stable(st_q.k));

    // R9: configuration frozen once out of reset
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        $stable(st_q.cfg));

endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner
    import rxwa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [WORD_WIDE-1:0] rx_word,
    input  logic                 align_req,
    input  logic                 cfg_wide,
    input  logic                 cfg_long,
    input  logic [PAT_MAX-1:0]   cfg_pattern,
    output logic [WORD_WIDE-1:0] aligned_word,
    output logic [OFF_W-1:0]     boundary,
    output logic                 sync_pulse,
    output logic                 pattern_seen
);

    cfg_t                 cfg_in, cfg_q;
    logic [STREAM_W-1:0]  stream;
    logic [PAT_MAX:0]     mask_ext;
    logic [PAT_MAX-1:0]   mask;
    logic [CNT_W-1:0]     wlen;
    logic [WORD_WIDE-1:0] hit;
    logic                 any;
    logic [OFF_W-1:0]     low;
    logic [WORD_WIDE-1:0] sliced;
    logic [OFF_W-1:0]     k_q;

    always_comb begin
        cfg_in.wide     = cfg_wide;
        cfg_in.long_pat = cfg_long;
        cfg_in.pattern  = cfg_pattern;
        mask_ext = ({{PAT_MAX{1'b0}}, 1'b1} << pat_len(cfg_q)) - 1'b1;
        mask     = mask_ext[PAT_MAX-1:0];
        wlen     = word_len(cfg_q);
    end

    rxwa_history #(.DW(WORD_WIDE), .NN(WORD_NARROW), .NW(HIST_WORDS)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .din    (rx_word),
        .wide   (cfg_q.wide),
        .stream (stream)
    );

    rxwa_matcher #(.DW(WORD_WIDE), .PW(PAT_MAX), .SW(STREAM_W)) u_match (
        .stream  (stream),
        .pattern (cfg_q.pattern),
        .mask    (mask),
        .wlen    (wlen),
        .hit     (hit),
        .any     (any),
        .low     (low)
    );

    rxwa_shifter #(.DW(WORD_WIDE), .NN(WORD_NARROW), .SW(STREAM_W)) u_shift (
        .stream (stream),
        .off    (k_q),
        .wide   (cfg_q.wide),
        .word   (sliced)
    );

    rxwa_ctrl #(.DW(WORD_WIDE)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_in    (cfg_in),
        .align_req (align_req),
        .hit       (hit),
        .any       (any),
        .low       (low),
        .word_in   (sliced),
        .cfg_q     (cfg_q),
        .k_q       (k_q),
        .sync_q    (sync_pulse),
        .detect_q  (pattern_seen),
        .dout_q    (aligned_word)
    );

    assign boundary = k_q;

endmodule

// File: tb/rx_word_aligner_test.sv
`timescale 1ns/1ps
module rx_word_aligner_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  rx_word = '0;
    logic        align_req = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cfg_long = 1'b0;
    logic [15:0] cfg_pattern = '0;
    logic [9:0]  aligned_word;
    logic [3:0]  boundary;
    logic        sync_pulse;
    logic        pattern_seen;

    always #2.5 clk = ~clk;

    rx_word_aligner uut (
        .clk          (clk),
        .rst          (rst),
        .rx_word      (rx_word),
        .align_req    (align_req),
        .cfg_wide     (cfg_wide),
        .cfg_long     (cfg_long),
        .cfg_pattern  (cfg_pattern),
        .aligned_word (aligned_word),
        .boundary     (boundary),
        .sync_pulse   (sync_pulse),
        .pattern_seen (pattern_seen)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state
    logic [9:0]  mh [3];
    int          m_k;
    bit          m_armed, m_req, m_wide, m_long;
    logic [15:0] m_pat;

    // serial bit source
    logic [63:0] pend;
    int          npend;
    bit          inject;

    function automatic int wlen_of();
        return m_wide ? 10 : 8;
    endfunction

    function automatic int plen_of();
        if (m_wide) return m_long ? 10 : 7;
        return m_long ? 16 : 8;
    endfunction

    function automatic logic sbit(int p);
        int w = wlen_of();
        int j = p / w;
        if (j > 2) return 1'b0;
        return mh[2-j][p % w];
    endfunction

    function automatic bit match_at(int k);
        if (k >= wlen_of()) return 0;
        for (int j = 0; j < plen_of(); j++) begin
            if (sbit(k + j) != m_pat[j]) return 0;
        end
        return 1;
    endfunction

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(bit wide, bit lng, logic [15:0] pat);
        @(negedge clk);
        rst = 1'b1; cfg_wide = wide; cfg_long = lng; cfg_pattern = pat;
        align_req = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) mh[i] = '0;
        m_k = 0; m_armed = 0; m_req = 0;
        m_wide = wide; m_long = lng; m_pat = pat;
        pend = '0; npend = 0; inject = 0;
        check("R9 reset word", aligned_word, 10'h0);
        check("R9 reset boundary", {6'h0, boundary}, 10'h0);
        check("R9 reset sync", {9'h0, sync_pulse}, 10'h0);
        check("R9 reset seen", {9'h0, pattern_seen}, 10'h0);
        // configuration inputs scrambled after reset must be ignored
        cfg_wide = ~wide; cfg_long = ~lng; cfg_pattern = ~pat;
    endtask

    task automatic step(logic [9:0] data, bit req);
        int low, w;
        bit rise, aeff, move, e_sync, e_seen;
        logic [9:0] e_word;
        rx_word = data; align_req = req;
        w = wlen_of();
        low = -1;
        for (int k = w - 1; k >= 0; k--) if (match_at(k)) low = k;
        e_seen = match_at(m_k);
        rise = req && !m_req;
        aeff = m_wide ? req : (m_armed || rise);
        move = aeff && (low >= 0);
        e_sync = move && (low != m_k);
        for (int i = 0; i < 10; i++) e_word[i] = (i < w) ? sbit(m_k + i) : 1'b0;
        @(posedge clk); @(negedge clk);
        m_k = move ? low : m_k;
        m_armed = m_wide ? 0 : (aeff && !(low >= 0));
        m_req = req;
        mh[2] = mh[1]; mh[1] = mh[0]; mh[0] = data;
        check("R5 R8 R9 aligned word", aligned_word, e_word);
        check(m_wide ? "R2 R4 R5 boundary" : "R1 R3 R5 boundary", {6'h0, boundary}, 10'(m_k));
        check(m_wide ? "R4 R6 sync" : "R3 R6 sync", {9'h0, sync_pulse}, {9'h0, e_sync});
        check(m_wide ? "R2 R7 seen" : "R1 R7 seen", {9'h0, pattern_seen}, {9'h0, e_seen});
    endtask

    function automatic logic [9:0] pull_word();
        int w = wlen_of();
        int l = plen_of();
        logic [9:0] r;
        while (npend < w) begin
            if (inject) begin
                pend = pend | ((64'(m_pat) & ((64'd1 << l) - 1)) << npend);
                npend += l;
                inject = 0;
            end else begin
                pend[npend] = 1'($urandom);
                npend++;
            end
        end
        r = 10'(pend & ((64'd1 << w) - 1));
        if (!m_wide) r[9:8] = 2'($urandom);
        pend = pend >> w;
        npend -= w;
        return r;
    endfunction

    task automatic run_random(int n);
        bit req = 0;
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(5) == 0) inject = 1;
            if (m_wide) req = ($urandom_range(2) == 0);
            else if ($urandom_range(7) == 0) req = ~req;
            step(pull_word(), req);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        // R1 16-bit pattern, 8-bit words
        do_reset(0, 1, 16'hF628);
        run_random(600);
        // R1 8-bit pattern; directed R5 lowest of several offsets
        do_reset(0, 0, 16'h0055);
        run_random(300);
        step(8'hAA, 0);
        step(8'hAA, 1);
        for (int i = 0; i < 4; i++) step(8'hAA, 1);
        step(8'h55, 0);
        step(8'h55, 1);
        for (int i = 0; i < 4; i++) step(8'h55, 1);
        // R2 10-bit pattern
        do_reset(1, 1, 16'h017C);
        run_random(600);
        // R2 7-bit pattern; R4 held request moves repeatedly
        do_reset(1, 0, 16'h007C);
        run_random(600);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all) actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule